// File: doc/BRIEF.md
# SPI Serial EEPROM Target Model

This block is a synthesizable SPI target, mode 0 only, that behaves like a small serial EEPROM. A controller lowers chip-select, shifts in an instruction byte and, for data commands, one or more address bytes (most significant first), then either streams data bytes in or clocks them out on MISO. The byte array and the page size are parameters. The bus pins are sampled in the system clock domain, so SCLK must run several times slower than `clk`.

Writes go through a latched write-enable bit, which a dedicated instruction sets. Data bytes for a page write are staged while chip-select is low. They reach the array only when chip-select rises on a byte boundary, and the address wraps inside the current page. A status register reports the write-enable latch, the block-protect field, the protect-enable flag and a busy flag. The busy flag stays set while a programmable timer models the internal write cycle. In 9-bit addressing mode, the address bit above the single address byte travels in bit 3 of the instruction byte.

Top module: `spi_eeprom_target`

## Requirements
- R1: Instruction 0x06 sets the write-enable latch and 0x04 clears it. The latch reads back as bit 1 of the status byte returned by instruction 0x05.
- R2: Instruction 0x02 (data write) and instruction 0x01 (status write) have no effect while the write-enable latch is clear.
- R3: When chip-select rises at the end of an accepted data-write or status-write instruction, the write-enable latch clears.
- R4: Instruction 0x03, followed by ADDR_BYTES address bytes sent MSB first, returns data MSB first. The first byte comes from the given address, and further bytes come from consecutive addresses for as long as chip-select stays low. The address wraps from the last byte of the array to address 0. MOSI is sampled on SCLK rising and MISO changes on SCLK falling.
- R5: With 9-bit addressing, bit 3 of the read or write instruction byte (0x0B, 0x0A) is address bit 8. Address bytes that differ only in that bit select distinct locations.
- R6: During a data write, the byte address advances within the current PAGE_BYTES-aligned page and wraps to the page start. Bytes outside that page are never changed.
- R7: Staged write bytes are committed only when chip-select rises on a byte boundary. A rise in the middle of a byte discards the whole write, and no busy cycle starts.
- R8: After a data write or status write is committed, status bit 0 reads 1 for WRITE_CYCLES clock cycles and then returns to 0.
- R9: While busy, every instruction except 0x05 is ignored. A write-enable issued while busy does not set the latch, and a read returns no data (MISO stays 0).
- R10: A status write updates only bit 7 (protect enable) and bits 3:2 (block-protect field). Bits 6:4 always read 0, and bits 1:0 follow the latch and busy state.
- R11: The block-protect field selects the protected area as follows: 00 protects nothing, 01 the upper quarter of the array, 10 the upper half, and 11 all of it. Committed bytes that fall in the protected area are discarded.
- R12: `miso_oe` is high only while chip-select is low and a read or status-read is returning data. At all other times `miso` is 0.
- R13: After reset the status byte is 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus pins are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip-select, active low |
| sclk | input | 1 | SPI serial clock, idle low (mode 0) |
| mosi | input | 1 | Serial data from controller |
| miso | output | 1 | Serial data to controller, 0 when not driving |
| miso_oe | output | 1 | High while the target returns data on MISO |

## Verification
The hardest cases to reach from the ports all involve the busy window. Instructions must land while the write-cycle timer is still running, and a write must be aborted by a chip-select rise partway through a byte. The bench runs the model with a long write cycle so that a full status read, a write-enable and a read can each be issued right after a commit. It then reads the status again after the timer expires, which shows that the latch and the array were left untouched. A partial-byte transfer routine produces the aborted write, and a status read afterwards confirms that no busy cycle started.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] A8_MASK  = 8'h08;

    typedef enum logic [2:0] {
        ST_OP,
        ST_ADDR,
        ST_READ,
        ST_WDATA,
        ST_RDSR,
        ST_WRSR,
        ST_SKIP
    } cmd_state_e;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
    } ee_prot_t;

    // True when addr lies inside the area the block-protect field covers.
    function automatic logic bp_covers(input logic [1:0] bp,
                                       input logic [31:0] addr,
                                       input logic [31:0] mem_bytes);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return addr >= (mem_bytes - (mem_bytes >> 2));
            2'b10:   return addr >= (mem_bytes >> 1);
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_ee_link.sv
module spi_ee_link (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic [7:0] tx_data,
    output logic       cs_act,
    output logic       cs_end,
    output logic       at_boundary,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       tx_take,
    output logic       tx_bit
);
    logic [1:0] sck_d;
    logic [1:0] csn_d;
    logic       mosi_d;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;
    logic       sck_rise;
    logic       sck_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 2'b00;
            csn_d  <= 2'b11;
            mosi_d <= 1'b0;
        end else begin
            sck_d  <= {sck_d[0], sclk};
            csn_d  <= {csn_d[0], cs_n};
            mosi_d <= mosi;
        end
    end

    assign cs_act      = ~csn_d[0];
    assign cs_end      = csn_d[0] & ~csn_d[1];
    assign sck_rise    = sck_d[0] & ~sck_d[1];
    assign sck_fall    = ~sck_d[0] & sck_d[1];
    assign at_boundary = (bit_cnt == 3'd0);
    assign tx_take     = cs_act & sck_fall & at_boundary;
    assign tx_bit      = tx_sr[7];

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            bit_cnt   <= 3'd0;
            rx_sr     <= 7'd0;
            tx_sr     <= 8'd0;
            byte_done <= 1'b0;
            rx_byte   <= 8'd0;
        end else begin
            byte_done <= 1'b0;
            if (sck_rise) begin
                rx_sr   <= {rx_sr[5:0], mosi_d};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sr, mosi_d};
                end
            end
            if (sck_fall) begin
                if (at_boundary) tx_sr <= tx_data;
                else             tx_sr <= {tx_sr[6:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
    parameter int CYCLES = 64,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 16,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          stage_clr,
    input  logic          stage_we,
    input  logic [AW-1:0] stage_addr,
    input  logic [7:0]    stage_data,
    input  logic          commit,
    input  logic [1:0]    bp
);
    logic [7:0]            mem  [MEM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvld;
    logic [AW-PW-1:0]      page_q;

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < MEM_BYTES; k++)  mem[k]  <= 8'hFF;
            for (int j = 0; j < PAGE_BYTES; j++) pbuf[j] <= 8'h00;
            pvld   <= '0;
            page_q <= '0;
        end else begin
            if (stage_clr) begin
                pvld <= '0;
            end else if (stage_we) begin
                pbuf[stage_addr[PW-1:0]] <= stage_data;
                pvld[stage_addr[PW-1:0]] <= 1'b1;
                page_q                   <= stage_addr[AW-1:PW];
            end
            if (commit) begin
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    if (pvld[i] && !spi_ee_pkg::bp_covers(bp, 32'({page_q, PW'(i)}),
                                                          32'(MEM_BYTES)))
                        mem[{page_q, PW'(i)}] <= pbuf[i];
                end
            end
        end
    end

endmodule

// File: rtl/spi_eeprom_target.sv
module spi_eeprom_target #(
    parameter int ADDR_BYTES    = 1,
    parameter bit NINE_BIT_ADDR = 1'b1,
    parameter int MEM_BYTES     = 512,
    parameter int PAGE_BYTES    = 16,
    parameter int WRITE_CYCLES  = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    import spi_ee_pkg::*;

    localparam int AW    = $clog2(MEM_BYTES);
    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int ABITS = ADDR_BYTES * 8;

    cmd_state_e       state;
    ee_prot_t         prot;
    logic             wel, a8_q, is_wr, have_data, have_sr, wr_cmd, out_en;
    logic [ABITS-1:0] addr_sr;
    logic [1:0]       addr_cnt;
    logic [AW-1:0]    rd_addr, wr_addr, full_addr;
    logic [7:0]       sr_new, status, tx_data, rd_data, rx_byte, op_key;
    logic             op_a8;
    logic             cs_act, cs_end, at_boundary, byte_done, tx_take, tx_bit;
    logic             busy, commit_w, commit_s, commit_any, stage_clr, stage_we;
    logic [ABITS-1:0] addr_next;
    logic [ABITS:0]   ext_addr;

    spi_ee_link u_link (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .tx_data(tx_data), .cs_act(cs_act), .cs_end(cs_end),
        .at_boundary(at_boundary), .byte_done(byte_done), .rx_byte(rx_byte),
        .tx_take(tx_take), .tx_bit(tx_bit)
    );

    spi_ee_wtimer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(commit_any), .busy(busy)
    );

    spi_ee_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .stage_clr(stage_clr), .stage_we(stage_we), .stage_addr(wr_addr),
        .stage_data(rx_byte), .commit(commit_w), .bp(prot.bp)
    );

    // Opcode key: in 9-bit mode, bit 3 of a read/write opcode is an address bit.
    generate
        if (NINE_BIT_ADDR) begin : g_nine
            logic [7:0] masked;
            assign masked = rx_byte & ~A8_MASK;
            assign op_a8  = rx_byte[3];
            assign op_key = (masked == OP_READ || masked == OP_WRITE) ? masked : rx_byte;
        end else begin : g_flat
            assign op_a8  = 1'b0;
            assign op_key = rx_byte;
        end
    endgenerate

    assign addr_next = ABITS'({addr_sr, rx_byte});
    assign ext_addr  = {a8_q, addr_next};
    assign full_addr = ext_addr[AW-1:0];

    assign status  = {prot.wpen, 3'b000, prot.bp, wel, busy};
    assign tx_data = (state == ST_RDSR) ? status : rd_data;
    assign miso    = out_en & tx_bit;
    assign miso_oe = out_en;

    assign stage_clr  = cs_act & byte_done & (state == ST_OP) & ~busy & wel
                        & (op_key == OP_WRITE);
    assign stage_we   = cs_act & byte_done & (state == ST_WDATA);
    assign commit_w   = cs_end & at_boundary & (state == ST_WDATA) & have_data;
    assign commit_s   = cs_end & at_boundary & (state == ST_WRSR) & have_sr;
    assign commit_any = commit_w | commit_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OP;
            prot      <= '0;
            wel       <= 1'b0;
            a8_q      <= 1'b0;
            is_wr     <= 1'b0;
            have_data <= 1'b0;
            have_sr   <= 1'b0;
            wr_cmd    <= 1'b0;
            out_en    <= 1'b0;
            addr_sr   <= '0;
            addr_cnt  <= '0;
            rd_addr   <= '0;
            wr_addr   <= '0;
            sr_new    <= '0;
        end else if (!cs_act) begin
            state     <= ST_OP;
            addr_cnt  <= '0;
            have_data <= 1'b0;
            have_sr   <= 1'b0;
            wr_cmd    <= 1'b0;
            out_en    <= 1'b0;
            if (cs_end && wr_cmd) wel <= 1'b0;
            if (commit_s) prot <= '{wpen: sr_new[7], bp: sr_new[3:2]};
        end else begin
            if (tx_take && (state == ST_READ || state == ST_RDSR)) out_en <= 1'b1;
            if (tx_take && state == ST_READ) rd_addr <= rd_addr + 1'b1;
            if (byte_done) begin
                case (state)
                    ST_OP: begin
                        if (busy && rx_byte != OP_RDSR) begin
                            state <= ST_SKIP;
                        end else begin
                            case (op_key)
                                OP_RDSR: state <= ST_RDSR;
                                OP_WREN: begin wel <= 1'b1; state <= ST_SKIP; end
                                OP_WRDI: begin wel <= 1'b0; state <= ST_SKIP; end
                                OP_WRSR: begin
                                    if (wel) begin state <= ST_WRSR; wr_cmd <= 1'b1; end
                                    else     state <= ST_SKIP;
                                end
                                OP_READ: begin
                                    state <= ST_ADDR;
                                    is_wr <= 1'b0;
                                    a8_q  <= op_a8;
                                end
                                OP_WRITE: begin
                                    if (wel) begin
                                        state  <= ST_ADDR;
                                        is_wr  <= 1'b1;
                                        a8_q   <= op_a8;
                                        wr_cmd <= 1'b1;
                                    end else begin
                                        state <= ST_SKIP;
                                    end
                                end
                                default: state <= ST_SKIP;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        addr_sr  <= addr_next;
                        addr_cnt <= addr_cnt + 2'd1;
                        if (addr_cnt == 2'(ADDR_BYTES - 1)) begin
                            if (is_wr) begin
                                state   <= ST_WDATA;
                                wr_addr <= full_addr;
                            end else begin
                                state   <= ST_READ;
                                rd_addr <= full_addr;
                            end
                        end
                    end
                    ST_WDATA: begin
                        wr_addr   <= {wr_addr[AW-1:PW], wr_addr[PW-1:0] + 1'b1};
                        have_data <= 1'b1;
                    end
                    ST_WRSR: begin
                        if (!have_sr) begin
                            sr_new  <= rx_byte;
                            have_sr <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic miso_oe,
    input logic busy,
    input logic wel,
    input logic commit_any
);
    // R12: two cycles of chip-select high leave the output driver off
    assert_oe_idle_R12: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) && $past(cs_n, 2)) |-> !miso_oe);

    // R7: a commit happens only right after chip-select went high
    assert_commit_on_cs_rise_R7: assert property (@(posedge clk) disable iff (rst)
        commit_any |-> ($past(cs_n) && !$past(cs_n, 2)));

    // R3: the latch is clear once a write has been committed
    assert_wel_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        commit_any |=> !wel);

    // R8: busy starts in the cycle after a commit
    assert_busy_starts_R8: assert property (@(posedge clk) disable iff (rst)
        commit_any |=> busy);

    // R9: the latch never gets set while busy
    assert_no_wren_busy_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> !$past(busy));

endmodule

bind spi_eeprom_target spi_ee_checker u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .miso_oe(miso_oe),
    .busy(busy), .wel(wel), .commit_any(commit_any)
);

// File: tb/spi_eeprom_target_tb.sv
module spi_eeprom_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WCYC       = 1000;
    localparam int BUSY_WAIT  = WCYC + 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [7:0] rbuf [8];
    logic [7:0] st;

    // Vector table: {address[8:0], data[7:0]}; each is written then read back.
    localparam logic [16:0] VEC [6] = '{
        {9'h000, 8'h11}, {9'h0FF, 8'h22}, {9'h100, 8'h33},
        {9'h1AB, 8'h44}, {9'h07F, 8'hA5}, {9'h1FE, 8'h5A}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_eeprom_target #(.WRITE_CYCLES(WCYC)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe)
    );

    task automatic clk_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int b = 7; b > 7 - nb; b--) begin
            mosi = tx[b];
            clk_wait(HALF);
            sclk = 1'b1;
            rx[b] = miso;
            clk_wait(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        clk_wait(4);
    endtask

    task automatic cs_finish();
        clk_wait(HALF);
        cs_n = 1'b1;
        clk_wait(8);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        cs_begin();
        xfer(op, d);
        cs_finish();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_begin();
        xfer(8'h05, d);
        xfer(8'h00, s);
        cs_finish();
    endtask

    task automatic write_seq(input logic [8:0] a, input int n, input logic [7:0] base);
        logic [7:0] d;
        cs_begin();
        xfer(8'h02 | {4'b0, a[8], 3'b0}, d);
        xfer(a[7:0], d);
        for (int i = 0; i < n; i++) xfer(base + 8'(i), d);
        cs_finish();
    endtask

    task automatic read_seq(input logic [8:0] a, input int n);
        logic [7:0] d;
        cs_begin();
        xfer(8'h03 | {4'b0, a[8], 3'b0}, d);
        xfer(a[7:0], d);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        cs_finish();
    endtask

    task automatic write_status(input logic [7:0] v);
        logic [7:0] d;
        cmd(8'h06);
        cs_begin();
        xfer(8'h01, d);
        xfer(v, d);
        cs_finish();
        clk_wait(BUSY_WAIT);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R13 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        clk_wait(6);
        rst = 1'b0;
        clk_wait(4);

        // R13 / R12: reset state
        rdsr(st);                      chk("R13 status after reset", st, 8'h00);
        chk("R12 oe idle", {6'b0, miso_oe, miso}, 8'h00);
        read_seq(9'h010, 1);           chk("R13 erased byte", rbuf[0], 8'hFF);

        // R1: latch set and cleared
        cmd(8'h06); rdsr(st);          chk("R1 WEL set", st, 8'h02);
        cmd(8'h04); rdsr(st);          chk("R1 WEL cleared", st, 8'h00);

        // R2: write ignored without latch
        write_seq(9'h020, 1, 8'h77);
        rdsr(st);                      chk("R2 no busy", st, 8'h00);
        read_seq(9'h020, 1);           chk("R2 byte kept", rbuf[0], 8'hFF);

        // R4 / R5: table of single-byte write/read pairs
        for (int v = 0; v < 6; v++) begin
            cmd(8'h06);
            write_seq(VEC[v][16:8], 1, VEC[v][7:0]);
            clk_wait(BUSY_WAIT);
            read_seq(VEC[v][16:8], 1);
            chk("R4 R5 table readback", rbuf[0], VEC[v][7:0]);
        end
        read_seq(9'h000, 1);           chk("R5 low half distinct", rbuf[0], 8'h11);

        // R8 / R3 / R9: busy window
        cmd(8'h06);
        write_seq(9'h030, 1, 8'h99);
        rdsr(st);                      chk("R8 R3 busy, WEL clear", st, 8'h01);
        cmd(8'h06);
        clk_wait(BUSY_WAIT);
        rdsr(st);                      chk("R9 WREN ignored while busy", st, 8'h00);
        read_seq(9'h030, 1);           chk("R8 committed byte", rbuf[0], 8'h99);
        cmd(8'h06);
        write_seq(9'h031, 1, 8'h66);
        read_seq(9'h031, 1);           chk("R9 read ignored while busy", rbuf[0], 8'h00);
        clk_wait(BUSY_WAIT);
        read_seq(9'h031, 1);           chk("R9 byte after busy", rbuf[0], 8'h66);

        // R6: page wrap
        cmd(8'h06);
        write_seq(9'h04E, 4, 8'hC0);
        clk_wait(BUSY_WAIT);
        read_seq(9'h04E, 2);
        chk("R6 page tail 0", rbuf[0], 8'hC0);
        chk("R6 page tail 1", rbuf[1], 8'hC1);
        read_seq(9'h040, 3);
        chk("R6 wrapped 0", rbuf[0], 8'hC2);
        chk("R6 wrapped 1", rbuf[1], 8'hC3);
        chk("R4 stream untouched", rbuf[2], 8'hFF);
        read_seq(9'h050, 1);           chk("R6 next page untouched", rbuf[0], 8'hFF);

        // R4: streaming read across end of array
        read_seq(9'h1FE, 3);
        chk("R4 end 0", rbuf[0], 8'h5A);
        chk("R4 end 1", rbuf[1], 8'hFF);
        chk("R4 wrap to 0", rbuf[2], 8'h11);

        // R7: chip-select rise mid-byte discards write
        cmd(8'h06);
        cs_begin();
        xfer(8'h02, d); xfer(8'h60, d); xfer(8'h12, d);
        xfer_bits(8'h34, 4, d);
        cs_finish();
        rdsr(st);                      chk("R7 R3 no busy, WEL clear", st, 8'h00);
        read_seq(9'h060, 1);           chk("R7 discarded", rbuf[0], 8'hFF);

        // R10 / R11: status write and protection
        write_status(8'hFC);
        rdsr(st);                      chk("R10 writable bits", st, 8'h8C);
        cmd(8'h06);
        write_seq(9'h070, 1, 8'h5C);
        clk_wait(BUSY_WAIT);
        read_seq(9'h070, 1);           chk("R11 all protected", rbuf[0], 8'hFF);
        write_status(8'h04);
        rdsr(st);                      chk("R10 R11 quarter mode", st, 8'h04);
        cmd(8'h06);
        write_seq(9'h190, 1, 8'h3C);
        clk_wait(BUSY_WAIT);
        read_seq(9'h190, 1);           chk("R11 upper quarter blocked", rbuf[0], 8'hFF);
        cmd(8'h06);
        write_seq(9'h170, 1, 8'h3D);
        clk_wait(BUSY_WAIT);
        read_seq(9'h170, 1);           chk("R11 below quarter written", rbuf[0], 8'h3D);
        write_status(8'h08);
        cmd(8'h06);
        write_seq(9'h150, 1, 8'h3E);
        clk_wait(BUSY_WAIT);
        read_seq(9'h150, 1);           chk("R11 upper half blocked", rbuf[0], 8'hFF);

        chk("R12 oe idle at end", {7'b0, miso_oe}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule